// File: doc/BRIEF.md
# SDRAM Bus Trace Capture

This block sits beside a 32-bit SDRAM bus that a memory controller drives while a debug or test mode is active. It does not touch the bus. It watches the command lines, the bank and multiplexed address lines, and the data bus on each rising edge of the memory clock. Each time the data strobe is high, it turns the transfer into one trace record. The record holds the full physical address, the 32-bit data word, the direction, a code-fetch flag and an error flag.

Address reconstruction depends on tracking rows per bank. An activate stores the row for its bank, and a precharge forgets it. A later column command is then combined with the stored row, so a page-hit access that issues only a column command still gets a complete address. Read data arrives a programmable number of clocks after its read command. The block therefore delays each read's address by the current CAS latency, so that back-to-back reads each pair with their own data beat. Records leave on a valid/ready stream through a four-entry queue. A sticky flag records that a record was lost.

Top module: `sdram_trace_cap`

## Requirements
- R1: A record is created only on a clock edge where `mem_strobe` is high, and exactly one record is created for each such edge. Data, fetch flag and command lines are all sampled on that same edge.
- R2: A command is decoded from `{mem_ras_n,mem_cas_n,mem_we_n}` when `mem_cs_n` is low. The codes are 011 activate, 101 read, 100 write, 010 precharge and 001 refresh. An activate stores `mem_addr` as the open row of bank `mem_bank`. A record address is `{bank, row, column}`, where column is `mem_addr[9:0]`, giving 25 bits.
- R3: When the strobe coincides with a write command, the record uses that cycle's bank, column and data. It has `tr_write`=1 and `tr_fetch`=0.
- R4: When the strobe falls `cas_lat` clocks after a read command (legal values 1 to 3), the record takes that read's bank, row and column. It has `tr_write`=0. This holds for reads issued on consecutive clocks.
- R5: A precharge closes bank `mem_bank` when `mem_addr[10]`=0, and closes every bank when `mem_addr[10]`=1. Other banks keep their rows.
- R6: A read or write command with `mem_addr[10]`=1 uses the open row, then closes its bank.
- R7: Refresh and any other command code leave all open rows unchanged.
- R8: A column command aimed at a closed bank produces a record with `tr_err`=1 and the row field (`tr_addr[22:10]`) zero.
- R9: A strobe that matches neither a same-cycle write nor a read `cas_lat` clocks earlier produces a record with `tr_err`=1, `tr_write`=0 and an all-zero address.
- R10: Up to four records are queued in arrival order. While `tr_valid` is high and `tr_ready` is low, the presented record stays unchanged. After reset the stream is empty.
- R11: A strobe that finds four records already queued drops its record and sets `tr_overflow`. The flag stays set until reset, even if a pop happens on the same edge.
- R12: On read and error records, `tr_fetch` carries `mem_fetch` as sampled with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; everything samples on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_strobe | input | 1 | Data-valid strobe from the bus |
| mem_fetch | input | 1 | Code-fetch indication from the bus |
| mem_cs_n | input | 1 | SDRAM chip select, active low |
| mem_ras_n | input | 1 | Row strobe command line |
| mem_cas_n | input | 1 | Column strobe command line |
| mem_we_n | input | 1 | Write enable command line |
| mem_bank | input | 2 | Bank address |
| mem_addr | input | 13 | Multiplexed row/column address |
| mem_data | input | 32 | Data bus |
| cas_lat | input | 2 | CAS latency in clocks (1 to 3) |
| tr_ready | input | 1 | Consumer accepts the presented record |
| tr_valid | output | 1 | A record is presented |
| tr_addr | output | 25 | Physical address {bank, row, column} |
| tr_data | output | 32 | Captured data word |
| tr_write | output | 1 | 1 for a write transfer, 0 for a read |
| tr_fetch | output | 1 | Code-fetch flag (always 0 on writes) |
| tr_err | output | 1 | Address could not be fully resolved |
| tr_overflow | output | 1 | Sticky: a record was dropped |

## Verification
The properties rely on two assumptions about the inputs. First, `cas_lat` stays in the range 1 to 3. Second, it is changed only on cycles with no strobe and no read still in flight, so a record never straddles two latency settings. The bench respects both: it moves the latency only after idle NOP cycles. The properties place no condition on `tr_ready`, so the stimulus exercises both a free-running consumer and a long stall that fills the queue past its depth.

// File: rtl/sdram_trace_pkg.sv
// Package: shared command type and decoder for the SDRAM trace capture.
// Assumes standard SDRAM command encoding on active-low lines.
package sdram_trace_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_OTHER
    } sdram_cmd_e;

    // Map the four command lines to a decoded command.
    function automatic sdram_cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                              input logic cas_n, input logic we_n);
        if (cs_n) return CMD_NOP;
        case ({ras_n, cas_n, we_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            default: return CMD_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/sdram_row_tracker.sv
// Module: sdram_row_tracker
// Holds one open/closed bit and one row register per bank. It reports the
// state of the bank addressed in the current cycle, as it stood before this
// cycle's command. Assumes the auto-precharge / precharge-all bit sits at
// AP_BIT of the multiplexed address.
module sdram_row_tracker
    import sdram_trace_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdram_cmd_e        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  addr,
    output logic              open_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam int NUM_BANKS = 1 << BANK_W;

    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    // Update per-bank row state from activate, precharge and auto-precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int i = 0; i < NUM_BANKS; i++) row_q[i] <= '0;
        end else begin
            case (cmd)
                CMD_ACT: begin
                    open_q[bank] <= 1'b1;
                    row_q[bank]  <= addr;
                end
                CMD_PRE: begin
                    if (addr[AP_BIT]) open_q <= '0;
                    else              open_q[bank] <= 1'b0;
                end
                CMD_RD, CMD_WR: begin
                    if (addr[AP_BIT]) open_q[bank] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Report the addressed bank's state before this cycle's update.
    always_comb begin
        open_o = open_q[bank];
        row_o  = row_q[bank];
    end

endmodule

// File: rtl/sdram_read_pipe.sv
// Module: sdram_read_pipe
// Delay line of read-command descriptors, MAX_CL stages long. A descriptor
// pushed on edge t sits in stage k after edge t+k. The stage picked by sel
// (sel-1) therefore holds the read issued sel clocks before the current edge.
// A sel of 0 or above MAX_CL selects nothing.
module sdram_read_pipe #(
    parameter int DESC_W = 26,
    parameter int MAX_CL = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DESC_W-1:0] push_desc,
    input  logic [SEL_W-1:0]  sel,
    output logic              out_valid,
    output logic [DESC_W-1:0] out_desc
);
    logic [MAX_CL-1:0] vld_all;
    logic [DESC_W-1:0] desc_all [MAX_CL];

    for (genvar k = 0; k < MAX_CL; k++) begin : g_stage
        logic              v_q;
        logic [DESC_W-1:0] d_q;
        if (k == 0) begin : g_head
            // First stage takes this cycle's read command.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else begin
                    v_q <= push;
                    d_q <= push_desc;
                end
            end
        end else begin : g_tail
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    d_q <= '0;
                end else begin
                    v_q <= vld_all[k-1];
                    d_q <= desc_all[k-1];
                end
            end
        end
        assign vld_all[k]  = v_q;
        assign desc_all[k] = d_q;
    end

    // Pick the stage matching the configured latency.
    always_comb begin
        out_valid = 1'b0;
        out_desc  = '0;
        for (int k = 0; k < MAX_CL; k++) begin
            if (int'(sel) == k + 1) begin
                out_valid = vld_all[k];
                out_desc  = desc_all[k];
            end
        end
    end

endmodule

// File: rtl/sdram_trace_fifo.sv
// Module: sdram_trace_fifo
// Small first-in first-out queue with a valid/ready output. The caller must
// not push while full. Pop and push may occur on the same edge.
module sdram_trace_fifo #(
    parameter int W     = 60,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    // Derive handshake events from occupancy.
    always_comb begin
        full      = (count_q == CNT_W'(DEPTH));
        out_valid = (count_q != '0);
        do_push   = push && !full;
        do_pop    = out_valid && out_ready;
        dout      = mem_q[rd_ptr_q];
    end

    // Store pushed records; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push)
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (do_pop)
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdram_trace_cap.sv
// Module: sdram_trace_cap (top)
// Passive capture of SDRAM bus transfers into a trace stream. It decodes
// commands, tracks open rows, delays read addresses by the CAS latency and
// builds one record per strobe. Assumes cas_lat is held steady while reads
// are in flight and that the strobe marks exactly the data beats.
module sdram_trace_cap
    import sdram_trace_pkg::*;
#(
    parameter int BANK_W     = 2,
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10,
    parameter int DATA_W     = 32,
    parameter int MAX_CL     = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int AP_BIT     = 10,
    parameter int CL_W       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mem_strobe,
    input  logic                          mem_fetch,
    input  logic                          mem_cs_n,
    input  logic                          mem_ras_n,
    input  logic                          mem_cas_n,
    input  logic                          mem_we_n,
    input  logic [BANK_W-1:0]             mem_bank,
    input  logic [ROW_W-1:0]              mem_addr,
    input  logic [DATA_W-1:0]             mem_data,
    input  logic [CL_W-1:0]               cas_lat,
    input  logic                          tr_ready,
    output logic                          tr_valid,
    output logic [BANK_W+ROW_W+COL_W-1:0] tr_addr,
    output logic [DATA_W-1:0]             tr_data,
    output logic                          tr_write,
    output logic                          tr_fetch,
    output logic                          tr_err,
    output logic                          tr_overflow
);
    localparam int PA_W    = BANK_W + ROW_W + COL_W;
    localparam int DESC_W  = 1 + PA_W;
    localparam int ENTRY_W = 3 + DATA_W + PA_W;

    sdram_cmd_e        cmd;
    logic              bank_open;
    logic [ROW_W-1:0]  bank_row;
    logic [ROW_W-1:0]  row_eff;
    logic [PA_W-1:0]   cur_pa;
    logic [DESC_W-1:0] cur_desc;
    logic              rd_hit;
    logic [DESC_W-1:0] rd_desc;
    logic [ENTRY_W-1:0] entry;
    logic              q_full;
    logic              q_push;
    logic [ENTRY_W-1:0] q_dout;
    logic              ovf_q;

    // Decode the bus command of this cycle.
    always_comb cmd = decode_cmd(mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n);

    sdram_row_tracker #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .AP_BIT (AP_BIT)
    ) i_rows (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .bank   (mem_bank),
        .addr   (mem_addr),
        .open_o (bank_open),
        .row_o  (bank_row)
    );

    // Form this cycle's physical address and error bit for a column command.
    always_comb begin
        row_eff  = bank_open ? bank_row : '0;
        cur_pa   = {mem_bank, row_eff, mem_addr[COL_W-1:0]};
        cur_desc = {!bank_open, cur_pa};
    end

    sdram_read_pipe #(
        .DESC_W (DESC_W),
        .MAX_CL (MAX_CL),
        .SEL_W  (CL_W)
    ) i_rdpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cmd == CMD_RD),
        .push_desc (cur_desc),
        .sel       (cas_lat),
        .out_valid (rd_hit),
        .out_desc  (rd_desc)
    );

    // Build the record: same-cycle write, delayed read, or unmatched error.
    always_comb begin
        if (cmd == CMD_WR)
            entry = {cur_desc[PA_W], 1'b0, 1'b1, mem_data, cur_pa};
        else if (rd_hit)
            entry = {rd_desc[PA_W], mem_fetch, 1'b0, mem_data, rd_desc[PA_W-1:0]};
        else
            entry = {1'b1, mem_fetch, 1'b0, mem_data, {PA_W{1'b0}}};
        q_push = mem_strobe && !q_full;
    end

    sdram_trace_fifo #(
        .W     (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .din       (entry),
        .full      (q_full),
        .out_valid (tr_valid),
        .out_ready (tr_ready),
        .dout      (q_dout)
    );

    // Remember that a strobe found the queue full.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (mem_strobe && q_full) ovf_q <= 1'b1;
    end

    // Unpack the head record onto the output fields.
    always_comb begin
        {tr_err, tr_fetch, tr_write, tr_data, tr_addr} = q_dout;
        tr_overflow = ovf_q;
    end

endmodule

// File: rtl/sdram_trace_chk.sv
// Module: sdram_trace_chk
// Port-level properties of the trace capture, bound onto the top module.
// Assumes cas_lat is kept in 1..MAX_CL by the environment.
module sdram_trace_chk #(
    parameter int PA_W   = 25,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 32,
    parameter int CL_W   = 2,
    parameter int MAX_CL = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_strobe,
    input logic [CL_W-1:0]   cas_lat,
    input logic              tr_ready,
    input logic              tr_valid,
    input logic [PA_W-1:0]   tr_addr,
    input logic [DATA_W-1:0] tr_data,
    input logic              tr_write,
    input logic              tr_fetch,
    input logic              tr_err,
    input logic              tr_overflow
);
    // R4
    cas_lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat != '0) && (int'(cas_lat) <= MAX_CL));

    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(tr_overflow));

    // R11
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tr_overflow) |-> $past(tr_valid && mem_strobe));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && !tr_ready |=> tr_valid &&
        $stable({tr_addr, tr_data, tr_write, tr_fetch, tr_err}));

    // R3
    write_fetch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && tr_write |-> !tr_fetch);

    // R8
    err_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && tr_err |-> tr_addr[COL_W +: ROW_W] == '0);

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_strobe |=> !$rose(tr_valid));

    // R1
    strobe_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_strobe && !tr_valid |=> tr_valid);

endmodule

bind sdram_trace_cap sdram_trace_chk #(
    .PA_W   (BANK_W + ROW_W + COL_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .CL_W   (CL_W),
    .MAX_CL (MAX_CL)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_strobe  (mem_strobe),
    .cas_lat     (cas_lat),
    .tr_ready    (tr_ready),
    .tr_valid    (tr_valid),
    .tr_addr     (tr_addr),
    .tr_data     (tr_data),
    .tr_write    (tr_write),
    .tr_fetch    (tr_fetch),
    .tr_err      (tr_err),
    .tr_overflow (tr_overflow)
);

// File: tb/test_sdram_trace_cap.sv
`timescale 1ns/1ps
module test_sdram_trace_cap;
    localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                           C_WR = 3'b100, C_PRE = 3'b010, C_REF = 3'b001,
                           C_MRS = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_strobe, mem_fetch, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_bank;
    logic [12:0] mem_addr;
    logic [31:0] mem_data;
    logic [1:0]  cas_lat;
    logic        tr_ready, tr_valid, tr_write, tr_fetch, tr_err, tr_overflow;
    logic [24:0] tr_addr;
    logic [31:0] tr_data;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R10 reset";

    // Reference model state.
    logic [59:0] q[$];
    logic [26:0] hist[$];
    bit          mopen[4];
    logic [12:0] mrow[4];
    bit          movf;

    always #2 clk = ~clk;

    sdram_trace_cap i_sdram_trace_cap (
        .clk(clk), .rst_n(rst_n), .mem_strobe(mem_strobe), .mem_fetch(mem_fetch),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_data(mem_data), .cas_lat(cas_lat), .tr_ready(tr_ready),
        .tr_valid(tr_valid), .tr_addr(tr_addr), .tr_data(tr_data),
        .tr_write(tr_write), .tr_fetch(tr_fetch), .tr_err(tr_err),
        .tr_overflow(tr_overflow)
    );

    task automatic check_out();
        logic [59:0] act, exp_e;
        bit          exp_v;
        exp_v = (q.size() > 0);
        exp_e = exp_v ? q[0] : '0;
        act   = {tr_err, tr_fetch, tr_write, tr_data, tr_addr};
        n_tests++;
        if (tr_valid !== exp_v || (exp_v && act !== exp_e) || tr_overflow !== movf) begin
            n_fail++;
            $display("FAIL %s: valid=%0b rec=%h ovf=%0b expected valid=%0b rec=%h ovf=%0b",
                     cur_req, tr_valid, act, tr_overflow, exp_v, exp_e, movf);
        end
    endtask

    task automatic cyc(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                       input logic s, input logic f, input logic [31:0] d,
                       input logic rdy);
        logic [59:0] e;
        logic [12:0] r;
        bit          full;
        int          cl;
        @(negedge clk);
        check_out();
        {mem_ras_n, mem_cas_n, mem_we_n} = c;
        mem_bank = b; mem_addr = a; mem_strobe = s; mem_fetch = f;
        mem_data = d; tr_ready = rdy;
        r  = mopen[b] ? mrow[b] : 13'd0;
        cl = int'(cas_lat);
        if (c == C_WR)
            e = {!mopen[b], 1'b0, 1'b1, d, b, r, a[9:0]};
        else if (cl >= 1 && hist.size() >= cl && hist[cl-1][26])
            e = {hist[cl-1][25], f, 1'b0, d, hist[cl-1][24:0]};
        else
            e = {1'b1, f, 1'b0, d, 25'd0};
        full = (q.size() == 4);
        if (rdy && q.size() > 0) void'(q.pop_front());
        if (s) begin
            if (full) movf = 1;
            else      q.push_back(e);
        end
        hist.push_front({c == C_RD, !mopen[b], b, r, a[9:0]});
        if (hist.size() > 3) void'(hist.pop_back());
        case (c)
            C_ACT: begin mopen[b] = 1; mrow[b] = a; end
            C_PRE: begin
                if (a[10]) for (int i = 0; i < 4; i++) mopen[i] = 0;
                else       mopen[b] = 0;
            end
            C_RD, C_WR: if (a[10]) mopen[b] = 0;
            default: ;
        endcase
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(C_NOP, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mopen[i] = 0; mrow[i] = 0; end
        movf = 0;
        rst_n = 0; mem_cs_n = 0; {mem_ras_n, mem_cas_n, mem_we_n} = C_NOP;
        mem_bank = 0; mem_addr = 0; mem_strobe = 0; mem_fetch = 0;
        mem_data = 0; cas_lat = 2; tr_ready = 1;
        repeat (3) @(negedge clk);
        check_out();               // R10 reset state: empty, no overflow
        rst_n = 1;

        cur_req = "R2 R4 page-miss read at latency 2";
        cyc(C_ACT, 1, 13'h1ABC, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 0, 0, 0, 1);
        cyc(C_RD, 1, 13'h155, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 1, 1, 32'hDEADBEEF, 1);
        idle(2);

        cur_req = "R3 page-hit write clears fetch";
        cyc(C_WR, 1, 13'h02A, 1, 1, 32'h12345678, 1);
        idle(2);

        cur_req = "R4 R12 back-to-back reads at latency 3";
        cas_lat = 3;
        cyc(C_ACT, 2, 13'h0F0F, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 0, 0, 0, 1);
        cyc(C_RD, 2, 13'h001, 0, 0, 0, 1);
        cyc(C_RD, 2, 13'h002, 0, 0, 0, 1);
        cyc(C_RD, 2, 13'h003, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 1, 1, 32'hA0000001, 1);
        cyc(C_NOP, 0, 0, 1, 0, 32'hA0000002, 1);
        cyc(C_NOP, 0, 0, 1, 1, 32'hA0000003, 1);
        idle(3);

        cur_req = "R4 latency 1";
        cas_lat = 1;
        cyc(C_RD, 2, 13'h007, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 1, 0, 32'hB0000007, 1);
        idle(2);

        cur_req = "R6 R8 auto-precharge then closed-bank write";
        cyc(C_RD, 2, 13'h405, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 1, 0, 32'hC0000005, 1);
        cyc(C_WR, 2, 13'h006, 1, 0, 32'hC0000006, 1);
        idle(2);

        cur_req = "R7 refresh and mode command keep rows";
        cyc(C_ACT, 3, 13'h0777, 0, 0, 0, 1);
        cyc(C_REF, 3, 13'h1FFF, 0, 0, 0, 1);
        cyc(C_MRS, 3, 13'h0000, 0, 0, 0, 1);
        cyc(C_WR, 3, 13'h009, 1, 0, 32'hD0000009, 1);
        idle(2);

        cur_req = "R5 single-bank precharge";
        cyc(C_ACT, 0, 13'h0123, 0, 0, 0, 1);
        cyc(C_PRE, 1, 13'h0000, 0, 0, 0, 1);
        cyc(C_WR, 0, 13'h001, 1, 0, 32'hE0000001, 1);
        cyc(C_PRE, 0, 13'h0000, 0, 0, 0, 1);
        cyc(C_WR, 0, 13'h002, 1, 0, 32'hE0000002, 1);
        cur_req = "R5 precharge all";
        cyc(C_ACT, 0, 13'h0AAA, 0, 0, 0, 1);
        cyc(C_ACT, 1, 13'h0BBB, 0, 0, 0, 1);
        cyc(C_PRE, 0, 13'h0400, 0, 0, 0, 1);
        cyc(C_WR, 1, 13'h003, 1, 0, 32'hE0000003, 1);
        cyc(C_WR, 3, 13'h004, 1, 0, 32'hE0000004, 1);
        idle(2);

        cur_req = "R9 unmatched strobes";
        cas_lat = 2;
        cyc(C_NOP, 0, 0, 1, 1, 32'hF0000000, 1);
        cyc(C_ACT, 3, 13'h0055, 0, 0, 0, 1);
        cyc(C_RD, 3, 13'h010, 0, 0, 0, 1);
        cyc(C_NOP, 0, 0, 1, 0, 32'hF0000001, 1);
        cyc(C_NOP, 0, 0, 0, 0, 0, 1);
        cyc(C_RD, 3, 13'h011, 1, 0, 32'hF0000002, 1);
        idle(4);

        cur_req = "R10 R11 backpressure and overflow";
        for (int i = 0; i < 6; i++)
            cyc(C_WR, 3, 13'(i), 1, 0, 32'h55000000 + i, 0);
        idle(0);
        for (int i = 0; i < 3; i++) cyc(C_NOP, 0, 0, 0, 0, 0, 0);
        cur_req = "R11 full with same-edge pop";
        cyc(C_WR, 3, 13'h020, 1, 0, 32'h66000000, 1);
        cur_req = "R10 drain in order";
        idle(6);
        cur_req = "R1 reads without strobe";
        cyc(C_RD, 3, 13'h030, 0, 0, 0, 1);
        idle(4);

        @(negedge clk);
        check_out();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule